// File: doc/BRIEF.md
# Vertical Blank Status Flag Timer

This block is the frame timer of a raster video controller. It steps a dot counter and a line counter once per dot clock. From the beam position it raises a vertical-blank flag when blanking starts. It clears that flag, together with a sprite-0-hit flag and a sprite-overflow flag, through one end-of-blanking strobe. The same strobe leaves the block so that the register file can end its post-reset warm-up.

The flags sit outside the reset domain. A reset moves the beam back to the top of the picture but leaves every flag as it was. The vertical-blank flag takes its power-on value from a parameter.

Reads of the status register are marked by a one-cycle strobe. A read returns the three flags in the cycle it is made, and the vertical-blank flag clears at the end of that cycle. A read that lands in the very cycle that would set the flag returns 0 for it, and the flag then stays clear for the rest of that frame. A parameter selects a 262-line frame or a 312-line frame, and another sets the number of dots per line.

Top module: `vblank_flag_timer`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, the counter returns to line 0, dot 0. The cycle after reset is released reads line 0, dot 0.
- R2: `dot` counts from 0 to DOTS_PER_LINE-1, then wraps to 0 and advances `line`. After the last line of the frame (261 for the 262-line frame), `line` wraps to 0.
- R3: Reset does not touch the status flags. The vertical-blank flag starts with the value INIT_VBLANK and keeps it through reset.
- R4: `statusFlags[2]` (the vertical-blank bit) becomes 1 at the clock edge that ends the cycle at line 241, dot 1, so it reads 1 from dot 2 of line 241.
- R5: `vblankEnd` is high exactly during the cycle at dot 1 of the last line, and only when not in reset. At the edge that ends that cycle, all three bits of `statusFlags` clear to 0.
- R6: `statusFlags` is {vertical blank, sprite-0 hit, sprite overflow} in bits 2, 1, 0. A cycle with `statusRead` high shows the current flags. The vertical-blank bit then clears at the end of that cycle, and bits 1 and 0 are left unchanged.
- R7: A read in the cycle at line 241, dot 1 shows 0 in bit 2. The vertical-blank bit then stays 0 until line 241 of the next frame.
- R8: A pulse on `sprHitSet` sets bit 1 and a pulse on `sprOvfSet` sets bit 0. Each bit holds until the end-of-blanking edge. A set pulse in the `vblankEnd` cycle is lost, because the clear wins.
- R9: With IS_PAL=1 the frame has 312 lines: `vblankEnd` falls on line 311, dot 1, and repeats every 312 × DOTS_PER_LINE cycles. With IS_PAL=0 the frame has 262 lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset of the beam counters |
| statusRead | input | 1 | One-cycle strobe marking a status register read |
| sprHitSet | input | 1 | Pulse that sets the sprite-0-hit flag |
| sprOvfSet | input | 1 | Pulse that sets the sprite-overflow flag |
| statusFlags | output | 3 | {vertical blank, sprite-0 hit, sprite overflow} |
| vblankEnd | output | 1 | End-of-blanking strobe, also the warm-up release |
| line | output | LINE_W (9) | Current line |
| dot | output | DOT_W (9) | Current dot |

## Verification
The bench goes after the read that lands exactly on the set cycle. A design that lets the set win there would report the flag one read late, or never drop it for that frame. The bench resets the block mid-frame while the flag is set; a design that clears the flags on reset would lose a blanking event that software still waits for. A sprite flag is pulsed in the same cycle as the end-of-blanking strobe, where the wrong priority leaves a stale flag standing into the next frame. A second instance runs the 312-line frame, where a hard-coded last line would put the strobe 50 lines early.

// File: rtl/vbt_pkg.sv
package vbt_pkg;
  // Strobes from beam-position control to the flag datapath.
  typedef struct packed {
    logic vblankStart;   // cycle that would set the blanking flag
    logic vblankEnd;     // cycle that clears all status flags
  } vbtStrobe_t;

  localparam int VBLANK_LINE = 241;
  localparam int NTSC_LINES  = 262;
  localparam int PAL_LINES   = 312;
endpackage

// File: rtl/vbt_raster_ctrl.sv
module vbt_raster_ctrl
  import vbt_pkg::*;
#(
  parameter int DOTS_PER_LINE = 341,
  parameter int LINES         = 262,
  parameter int LINE_W        = 9,
  parameter int DOT_W         = 9
) (
  input  logic              clk,
  input  logic              rst,
  output logic [LINE_W-1:0] lineCnt,
  output logic [DOT_W-1:0]  dotCnt,
  output vbtStrobe_t        strobes
);
  localparam logic [DOT_W-1:0]  LastDot  = DOT_W'(DOTS_PER_LINE - 1);
  localparam logic [LINE_W-1:0] LastLine = LINE_W'(LINES - 1);
  localparam logic [LINE_W-1:0] SetLine  = LINE_W'(VBLANK_LINE);
  localparam logic [DOT_W-1:0]  EventDot = DOT_W'(1);

  logic atLastDot;
  assign atLastDot = (dotCnt == LastDot);

  always_ff @(posedge clk) begin
    if (rst) begin
      lineCnt <= '0;
      dotCnt  <= '0;
    end else if (atLastDot) begin
      dotCnt  <= '0;
      lineCnt <= (lineCnt == LastLine) ? '0 : lineCnt + 1'b1;
    end else begin
      dotCnt <= dotCnt + 1'b1;
    end
  end

  // Position decode; reset masks both events.
  always_comb begin
    strobes.vblankStart = ~rst & (lineCnt == SetLine)  & (dotCnt == EventDot);
    strobes.vblankEnd   = ~rst & (lineCnt == LastLine) & (dotCnt == EventDot);
  end
endmodule

// File: rtl/vbt_status_path.sv
module vbt_status_path
  import vbt_pkg::*;
#(
  parameter bit INIT_VBLANK = 1'b0
) (
  input  logic       clk,
  input  vbtStrobe_t strobes,
  input  logic       statusRead,
  input  logic       sprHitSet,
  input  logic       sprOvfSet,
  output logic [2:0] flagsOut
);
  // Flags live outside the reset domain; power-on value only.
  logic       vblankFlag = INIT_VBLANK;
  logic [1:0] stickyFlag = 2'b00;
  logic [1:0] stickySet;

  assign stickySet = {sprHitSet, sprOvfSet};

  always_ff @(posedge clk) begin
    if (strobes.vblankEnd)
      vblankFlag <= 1'b0;
    else if (statusRead)
      vblankFlag <= 1'b0;        // read on the set cycle suppresses the set
    else if (strobes.vblankStart)
      vblankFlag <= 1'b1;
  end

  for (genvar i = 0; i < 2; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (strobes.vblankEnd)
        stickyFlag[i] <= 1'b0;
      else if (stickySet[i])
        stickyFlag[i] <= 1'b1;
    end
  end

  assign flagsOut = {vblankFlag, stickyFlag};
endmodule

// File: rtl/vblank_flag_timer.sv
module vblank_flag_timer
  import vbt_pkg::*;
#(
  parameter int DOTS_PER_LINE = 341,
  parameter bit IS_PAL        = 1'b0,
  parameter bit INIT_VBLANK   = 1'b0,
  localparam int LINES  = IS_PAL ? PAL_LINES : NTSC_LINES,
  localparam int LINE_W = $clog2(LINES),
  localparam int DOT_W  = $clog2(DOTS_PER_LINE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              statusRead,
  input  logic              sprHitSet,
  input  logic              sprOvfSet,
  output logic [2:0]        statusFlags,
  output logic              vblankEnd,
  output logic [LINE_W-1:0] line,
  output logic [DOT_W-1:0]  dot
);
  vbtStrobe_t strobes;

  vbt_raster_ctrl #(
    .DOTS_PER_LINE(DOTS_PER_LINE),
    .LINES(LINES),
    .LINE_W(LINE_W),
    .DOT_W(DOT_W)
  ) u_ctrl (
    .clk(clk),
    .rst(rst),
    .lineCnt(line),
    .dotCnt(dot),
    .strobes(strobes)
  );

  vbt_status_path #(
    .INIT_VBLANK(INIT_VBLANK)
  ) u_path (
    .clk(clk),
    .strobes(strobes),
    .statusRead(statusRead),
    .sprHitSet(sprHitSet),
    .sprOvfSet(sprOvfSet),
    .flagsOut(statusFlags)
  );

  assign vblankEnd = strobes.vblankEnd;
endmodule

// File: rtl/vbt_checker.sv
module vbt_checker #(
  parameter int DOTS_PER_LINE = 341,
  parameter int LINES         = 262,
  parameter int LINE_W        = 9,
  parameter int DOT_W         = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              statusRead,
  input logic              sprHitSet,
  input logic              sprOvfSet,
  input logic [2:0]        statusFlags,
  input logic              vblankEnd,
  input logic [LINE_W-1:0] line,
  input logic [DOT_W-1:0]  dot
);
  AST_RESET_HOME: assert property (@(posedge clk)
    rst |=> (line == '0 && dot == '0)); // R1

  AST_DOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (int'(dot) == DOTS_PER_LINE - 1) |=> (dot == '0)); // R2

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (int'(line) == LINES - 1 && int'(dot) == DOTS_PER_LINE - 1) |=> (line == '0)); // R2

  AST_FLAGS_KEPT_IN_RESET: assert property (@(posedge clk)
    (rst && !statusRead && !sprHitSet && !sprOvfSet) |=> $stable(statusFlags)); // R3

  AST_VBLANK_SET: assert property (@(posedge clk) disable iff (rst)
    (int'(line) == 241 && int'(dot) == 1 && !statusRead) |=> statusFlags[2]); // R4

  AST_END_PLACE: assert property (@(posedge clk)
    vblankEnd |-> (int'(line) == LINES - 1 && int'(dot) == 1)); // R5

  AST_END_CLEAR: assert property (@(posedge clk) disable iff (rst)
    vblankEnd |=> (statusFlags == 3'b000)); // R5

  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    statusRead |=> !statusFlags[2]); // R6

  AST_RACE_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
    (int'(line) == 241 && int'(dot) == 1 && statusRead) |=> !statusFlags[2]); // R7

  AST_STICKY_HIT: assert property (@(posedge clk) disable iff (rst)
    (sprHitSet && !vblankEnd) |=> statusFlags[1]); // R8
endmodule

bind vblank_flag_timer vbt_checker #(
  .DOTS_PER_LINE(DOTS_PER_LINE),
  .LINES(LINES),
  .LINE_W(LINE_W),
  .DOT_W(DOT_W)
) u_vbt_checker (
  .clk(clk),
  .rst(rst),
  .statusRead(statusRead),
  .sprHitSet(sprHitSet),
  .sprOvfSet(sprOvfSet),
  .statusFlags(statusFlags),
  .vblankEnd(vblankEnd),
  .line(line),
  .dot(dot)
);

// File: tb/tb_vblank_flag_timer.sv
`timescale 1ns/1ps
module tb_vblank_flag_timer;
  localparam int CLK_PERIOD = 10;
  localparam int TB_DOTS    = 20;
  localparam int NTSC_LAST  = 261;
  localparam int PAL_FRAME  = 312 * TB_DOTS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rstPal = 1'b1;
  logic statusRead = 1'b0, sprHitSet = 1'b0, sprOvfSet = 1'b0;
  logic [2:0] statusFlags, palFlags;
  logic vblankEnd, palEnd;
  logic [8:0] line, palLine;
  logic [4:0] dot, palDot;

  always #(CLK_PERIOD/2) clk = ~clk;

  vblank_flag_timer #(.DOTS_PER_LINE(TB_DOTS), .IS_PAL(1'b0), .INIT_VBLANK(1'b1)) dut (
    .clk(clk), .rst(rst), .statusRead(statusRead), .sprHitSet(sprHitSet),
    .sprOvfSet(sprOvfSet), .statusFlags(statusFlags), .vblankEnd(vblankEnd),
    .line(line), .dot(dot));

  vblank_flag_timer #(.DOTS_PER_LINE(TB_DOTS), .IS_PAL(1'b1), .INIT_VBLANK(1'b0)) dutPal (
    .clk(clk), .rst(rstPal), .statusRead(1'b0), .sprHitSet(1'b0),
    .sprOvfSet(1'b0), .statusFlags(palFlags), .vblankEnd(palEnd),
    .line(palLine), .dot(palDot));

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model of the main instance.
  int mLine = 0, mDot = 0;
  bit mVb = 1'b1, mHit = 1'b0, mOvf = 1'b0;

  always @(posedge clk) begin
    bit setEv, clrEv;
    setEv = !rst && mLine == 241 && mDot == 1;
    clrEv = !rst && mLine == NTSC_LAST && mDot == 1;
    if (clrEv) begin mVb = 0; mHit = 0; mOvf = 0; end
    else begin
      if (statusRead) mVb = 0;
      else if (setEv) mVb = 1;
      if (sprHitSet) mHit = 1;
      if (sprOvfSet) mOvf = 1;
    end
    if (rst) begin mLine = 0; mDot = 0; end
    else if (mDot == TB_DOTS - 1) begin
      mDot = 0;
      mLine = (mLine == NTSC_LAST) ? 0 : mLine + 1;
    end else mDot = mDot + 1;
  end

  // Compare every cycle, away from the clock edge.
  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk("R2", "line", int'(line), mLine);
      chk("R2", "dot", int'(dot), mDot);
      chk("R4", "vblank bit", int'(statusFlags[2]), int'(mVb));
      chk("R8", "sprite bits", int'(statusFlags[1:0]), int'({mHit, mOvf}));
      chk("R5", "end strobe", int'(vblankEnd), int'(!rst && mLine == NTSC_LAST && mDot == 1));
    end
  end

  // 312-line instance monitor.
  int palCycle = 0, palLast = -1;
  always @(negedge clk) begin
    #1;
    if (!done && !rstPal) begin
      palCycle++;
      if (palEnd) begin
        chk("R9", "pal strobe line", int'(palLine), 311);
        chk("R9", "pal strobe dot", int'(palDot), 1);
        if (palLast >= 0) chk("R9", "pal frame length", palCycle - palLast, PAL_FRAME);
        palLast = palCycle;
      end
      if (int'(palLine) == 241 && int'(palDot) == 2)
        chk("R4", "pal vblank set", int'(palFlags[2]), 1);
    end
  end

  task automatic waitAt(input int l, input int d);
    do @(negedge clk); while (!(mLine == l && mDot == d));
  endtask

  initial begin
    @(negedge clk); #1;
    chk("R3", "power-on vblank", int'(statusFlags[2]), 1);
    repeat (2) @(negedge clk);
    rst = 1'b0; rstPal = 1'b0;
    #1;
    chk("R1", "line after reset", int'(line), 0);
    chk("R1", "dot after reset", int'(dot), 0);
    chk("R3", "vblank kept over reset", int'(statusFlags[2]), 1);

    // Frame A: sprite hit, normal read, overflow pulse on the clear cycle.
    waitAt(100, 4); sprHitSet = 1'b1;
    @(negedge clk); sprHitSet = 1'b0; #1;
    chk("R8", "hit bit set", int'(statusFlags[1]), 1);
    waitAt(245, 3); statusRead = 1'b1; #1;
    chk("R6", "read returns flag", int'(statusFlags[2]), 1);
    @(negedge clk); statusRead = 1'b0; #1;
    chk("R6", "flag cleared by read", int'(statusFlags[2]), 0);
    chk("R6", "hit bit kept by read", int'(statusFlags[1]), 1);
    waitAt(NTSC_LAST, 1); sprOvfSet = 1'b1;
    @(negedge clk); sprOvfSet = 1'b0; #1;
    chk("R8", "set lost on clear cycle", int'(statusFlags[0]), 0);
    chk("R5", "all flags cleared", int'(statusFlags), 0);

    // Frame B: read exactly on the set cycle.
    waitAt(241, 1); statusRead = 1'b1; #1;
    chk("R7", "race read returns 0", int'(statusFlags[2]), 0);
    @(negedge clk); statusRead = 1'b0;
    waitAt(260, 0); #1;
    chk("R7", "flag stays clear for frame", int'(statusFlags[2]), 0);

    // Frame C: reset mid-blanking with the flag set.
    waitAt(250, 5); #1;
    chk("R4", "flag set before reset", int'(statusFlags[2]), 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; #1;
    chk("R1", "line after mid reset", int'(line), 0);
    chk("R1", "dot after mid reset", int'(dot), 0);
    chk("R3", "flag survives mid reset", int'(statusFlags[2]), 1);

    // Frame D: normal set and clear.
    waitAt(NTSC_LAST, 2); #1;
    chk("R5", "cleared at frame end", int'(statusFlags), 0);
    waitAt(241, 2); #1;
    chk("R4", "flag set at line 241 dot 2", int'(statusFlags[2]), 1);
    chk("R9", "pal strobes seen", int'(palLast > 0), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: run hung actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule